// File: doc/BRIEF.md
# Single-Wire Three-Slot Scan Deserializer

This block sits between the pins of a compact debug port and a JTAG TAP state tracker. While the link is in its single-wire scan mode, one bidirectional data line carries all three JTAG signals, one after another. Each JTAG bit takes three TCK periods. The first slot carries TDI at inverted polarity, the second carries TMS, and the third carries TDO. The block samples the line once per TCK rising edge and collects the three slot values. After the third slot it emits one single-cycle strobe that presents all three reconstructed values together.

When the link is in plain four-wire mode, the block passes the TDI, TMS and TDO pin samples through, with one strobe for every TCK rising edge. Mode activation is detected elsewhere and arrives as a level input. TCK rising edges arrive as a one-cycle pulse in the system clock domain. Right after the single-wire mode is entered, the block treats the first edge as the TMS slot. The first bit after entry therefore completes on the second edge and presents the TDI value held from the last TDI slot seen.

Top module: `oscan1_deserializer`

## Requirements
- R1: While reset is high and in the first cycle after it, `bit_vld`, `bit_tdi`, `bit_tms` and `bit_tdo` are all 0.
- R2: With `oscan_mode` low, every cycle with `tck_rise` high gives `bit_vld` = 1 in the following cycle. In that cycle `bit_tdi`, `bit_tms` and `bit_tdo` equal `tdi_in`, `tms_in` and `tdo_in` as they were sampled at the edge.
- R3: With `oscan_mode` high and held, the edges fall into repeating groups of three slots in the order TDI, TMS, TDO. `bit_vld` pulses for exactly one cycle, and only in the cycle after the TDO-slot edge, so no more than three single-wire edges occur between strobes.
- R4: The TDI value presented is the inverse of the `tmsc_in` level at the TDI-slot edge: low gives 1 and high gives 0.
- R5: The TMS value presented is the `tmsc_in` level at the TMS-slot edge. The TDO value is the `tmsc_in` level at the TDO-slot edge.
- R6: The first edge after `oscan_mode` rises is taken as the TMS slot. The next edge completes the bit, which presents the TDI value from the most recent TDI slot, or 0 if there has been none since reset.
- R7: When `oscan_mode` falls, a partly collected bit is dropped without a strobe. The slot count restarts, so that R6 applies again at the next entry.
- R8: `bit_vld` is never 1 unless `tck_rise` was high in the cycle before. Between strobes, `bit_tdi`, `bit_tms` and `bit_tdo` keep their values.
- R9: `tmsc_in` has no effect in four-wire mode. `tdi_in`, `tms_in` and `tdo_in` have no effect in single-wire mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oscan_mode | input | 1 | 1 = single-wire three-slot mode active, 0 = four-wire |
| tck_rise | input | 1 | One-cycle pulse marking a TCK rising edge |
| tmsc_in | input | 1 | Sampled level of the shared single-wire data line |
| tdi_in | input | 1 | Sampled TDI pin (four-wire mode) |
| tms_in | input | 1 | Sampled TMS pin (four-wire mode) |
| tdo_in | input | 1 | Sampled TDO pin (four-wire mode) |
| bit_vld | output | 1 | One-cycle strobe: a complete JTAG bit is presented |
| bit_tdi | output | 1 | Reconstructed TDI |
| bit_tms | output | 1 | Reconstructed TMS |
| bit_tdo | output | 1 | Reconstructed TDO |

## Verification
Several rules are checked by assertions on every cycle:
- four-wire pass-through;
- single-wire TDO taken straight from the line;
- no strobe without an edge;
- output hold between strobes;
- the bound of three single-wire edges per strobe.

The inverted TDI slot, the shortened first bit after entry with its carried-over TDI, and the dropped partial bit at exit depend on sequences across mode changes. Only the bench's scenarios show these: directed bit patterns, mid-bit exits and a long random run, all compared against a queue-based model.

// File: rtl/oscan1_pkg.sv
package oscan1_pkg;
  localparam int unsigned SLOTS_PER_BIT = 3;
  localparam int unsigned SLOT_W        = $clog2(SLOTS_PER_BIT);

  typedef enum logic [SLOT_W-1:0] {
    SLOT_TDI = 2'd0,
    SLOT_TMS = 2'd1,
    SLOT_TDO = 2'd2
  } slot_e;

  typedef struct packed {
    logic tdi;
    logic tms;
    logic tdo;
  } jbit_t;

  function automatic slot_e slot_succ(input slot_e s);
    case (s)
      SLOT_TDI: slot_succ = SLOT_TMS;
      SLOT_TMS: slot_succ = SLOT_TDO;
      default:  slot_succ = SLOT_TDI;
    endcase
  endfunction
endpackage

// File: rtl/oscan1_phase_ctr.sv
module oscan1_phase_ctr
  import oscan1_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  oscan_mode,
  input  logic  tck_rise,
  output slot_e cur_slot,
  output logic  slot_take
);
  logic  mode_q;
  slot_e ph_q;

  // On the first cycle of the mode the stored phase is bypassed: entry starts at TMS.
  always_comb begin
    cur_slot  = mode_q ? ph_q : SLOT_TMS;
    slot_take = oscan_mode & tck_rise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      ph_q   <= SLOT_TDI;
    end else begin
      mode_q <= oscan_mode;
      if (!oscan_mode)
        ph_q <= SLOT_TDI;
      else if (tck_rise)
        ph_q <= slot_succ(cur_slot);
      else
        ph_q <= cur_slot;
    end
  end
endmodule

// File: rtl/oscan1_slot_capture.sv
module oscan1_slot_capture
  import oscan1_pkg::*;
#(
  parameter bit TDI_ACTIVE_LOW = 1'b1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  slot_take,
  input  slot_e cur_slot,
  input  logic  tmsc_in,
  output jbit_t line_bit,
  output logic  line_done
);
  logic tdi_level;
  logic tdi_hold_q;
  logic tms_hold_q;

  generate
    if (TDI_ACTIVE_LOW) begin : g_tdi_inv
      assign tdi_level = ~tmsc_in;
    end else begin : g_tdi_true
      assign tdi_level = tmsc_in;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      tdi_hold_q <= 1'b0;
      tms_hold_q <= 1'b0;
    end else if (slot_take) begin
      if (cur_slot == SLOT_TDI) tdi_hold_q <= tdi_level;
      if (cur_slot == SLOT_TMS) tms_hold_q <= tmsc_in;
    end
  end

  always_comb begin
    line_bit.tdi = tdi_hold_q;
    line_bit.tms = tms_hold_q;
    line_bit.tdo = tmsc_in;
    line_done    = slot_take && (cur_slot == SLOT_TDO);
  end
endmodule

// File: rtl/oscan1_strobe_reg.sv
module oscan1_strobe_reg
  import oscan1_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  oscan_mode,
  input  logic  tck_rise,
  input  jbit_t pin_bit,
  input  jbit_t line_bit,
  input  logic  line_done,
  output logic  vld_q,
  output jbit_t bit_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      bit_q <= '0;
    end else begin
      vld_q <= 1'b0;
      if (!oscan_mode && tck_rise) begin
        vld_q <= 1'b1;
        bit_q <= pin_bit;
      end else if (oscan_mode && line_done) begin
        vld_q <= 1'b1;
        bit_q <= line_bit;
      end
    end
  end
endmodule

// File: rtl/oscan1_deserializer.sv
module oscan1_deserializer
  import oscan1_pkg::*;
#(
  parameter bit TDI_ACTIVE_LOW = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic oscan_mode,
  input  logic tck_rise,
  input  logic tmsc_in,
  input  logic tdi_in,
  input  logic tms_in,
  input  logic tdo_in,
  output logic bit_vld,
  output logic bit_tdi,
  output logic bit_tms,
  output logic bit_tdo
);
  slot_e cur_slot;
  logic  slot_take;
  logic  line_done;
  jbit_t line_bit;
  jbit_t pin_bit;
  jbit_t bit_q;

  assign pin_bit = '{tdi: tdi_in, tms: tms_in, tdo: tdo_in};

  oscan1_phase_ctr u_phase (
    .clk        (clk),
    .rst        (rst),
    .oscan_mode (oscan_mode),
    .tck_rise   (tck_rise),
    .cur_slot   (cur_slot),
    .slot_take  (slot_take)
  );

  oscan1_slot_capture #(.TDI_ACTIVE_LOW(TDI_ACTIVE_LOW)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .slot_take (slot_take),
    .cur_slot  (cur_slot),
    .tmsc_in   (tmsc_in),
    .line_bit  (line_bit),
    .line_done (line_done)
  );

  oscan1_strobe_reg u_out (
    .clk        (clk),
    .rst        (rst),
    .oscan_mode (oscan_mode),
    .tck_rise   (tck_rise),
    .pin_bit    (pin_bit),
    .line_bit   (line_bit),
    .line_done  (line_done),
    .vld_q      (bit_vld),
    .bit_q      (bit_q)
  );

  assign bit_tdi = bit_q.tdi;
  assign bit_tms = bit_q.tms;
  assign bit_tdo = bit_q.tdo;
endmodule

// File: rtl/oscan1_deserializer_chk.sv
module oscan1_deserializer_chk (
  input logic clk,
  input logic rst,
  input logic oscan_mode,
  input logic tck_rise,
  input logic tmsc_in,
  input logic tdi_in,
  input logic tms_in,
  input logic tdo_in,
  input logic bit_vld,
  input logic bit_tdi,
  input logic bit_tms,
  input logic bit_tdo
);
  logic [2:0] edges_q;

  // Single-wire edges seen since the last strobe.
  always_ff @(posedge clk) begin
    if (rst || !oscan_mode)
      edges_q <= 3'd0;
    else if (bit_vld)
      edges_q <= tck_rise ? 3'd1 : 3'd0;
    else if (tck_rise)
      edges_q <= edges_q + 3'd1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!bit_vld && !bit_tdi && !bit_tms && !bit_tdo));

  assert_fourwire_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (tck_rise && !oscan_mode) |=> (bit_vld && bit_tdi == $past(tdi_in)
                                   && bit_tms == $past(tms_in) && bit_tdo == $past(tdo_in)));

  assert_three_slots_R3: assert property (@(posedge clk) disable iff (rst)
    edges_q <= 3'd3);

  assert_tdo_direct_R5: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && $past(oscan_mode)) |-> (bit_tdo == $past(tmsc_in)));

  assert_strobe_needs_edge_R8: assert property (@(posedge clk) disable iff (rst)
    !tck_rise |=> !bit_vld);

  assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |-> $stable({bit_tdi, bit_tms, bit_tdo}));
endmodule

bind oscan1_deserializer oscan1_deserializer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .oscan_mode (oscan_mode),
  .tck_rise   (tck_rise),
  .tmsc_in    (tmsc_in),
  .tdi_in     (tdi_in),
  .tms_in     (tms_in),
  .tdo_in     (tdo_in),
  .bit_vld    (bit_vld),
  .bit_tdi    (bit_tdi),
  .bit_tms    (bit_tms),
  .bit_tdo    (bit_tdo)
);

// File: tb/sim_oscan1_deserializer.sv
`timescale 1ns/1ps
module sim_oscan1_deserializer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic oscan_mode = 1'b0, tck_rise = 1'b0, tmsc_in = 1'b0;
  logic tdi_in = 1'b0, tms_in = 1'b0, tdo_in = 1'b0;
  logic bit_vld, bit_tdi, bit_tms, bit_tdo;

  int vectors = 0;
  int errors  = 0;
  string cur_req = "R1";
  bit finished = 1'b0;

  always #4 clk = ~clk;

  oscan1_deserializer u0 (
    .clk(clk), .rst(rst), .oscan_mode(oscan_mode), .tck_rise(tck_rise),
    .tmsc_in(tmsc_in), .tdi_in(tdi_in), .tms_in(tms_in), .tdo_in(tdo_in),
    .bit_vld(bit_vld), .bit_tdi(bit_tdi), .bit_tms(bit_tms), .bit_tdo(bit_tdo)
  );

  // Reference model: the line levels of the current bit are kept in a queue.
  bit q[$];
  bit last_tdi, prev_mode;
  bit e_vld, e_tdi, e_tms, e_tdo;

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      last_tdi = 0; prev_mode = 0;
      e_vld = 0; e_tdi = 0; e_tms = 0; e_tdo = 0;
    end else begin
      e_vld = 0;
      if (oscan_mode) begin
        if (!prev_mode) begin
          q.delete();
          q.push_back(!last_tdi);   // entry: TDI slot is skipped
        end
        if (tck_rise) begin
          if (q.size() == 0) last_tdi = !tmsc_in;
          q.push_back(tmsc_in);
          if (q.size() == 3) begin
            e_vld = 1; e_tdi = !q[0]; e_tms = q[1]; e_tdo = q[2];
            q.delete();
          end
        end
      end else begin
        q.delete();
        if (tck_rise) begin
          e_vld = 1; e_tdi = tdi_in; e_tms = tms_in; e_tdo = tdo_in;
        end
      end
      prev_mode = oscan_mode;
    end
  end

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk(cur_req, "bit_vld", bit_vld, e_vld);
    chk(cur_req, "bit_tdi", bit_tdi, e_tdi);
    chk(cur_req, "bit_tms", bit_tms, e_tms);
    chk(cur_req, "bit_tdo", bit_tdo, e_tdo);
  endtask

  task automatic edge_line(input logic v);
    tmsc_in = v; tck_rise = 1'b1;
    tdi_in = 1'($urandom); tms_in = 1'($urandom); tdo_in = 1'($urandom);
    tick();
    tck_rise = 1'b0;
    tick();
  endtask

  task automatic send_bit(input logic tdi, input logic tms, input logic tdo);
    tmsc_in = !tdi; tck_rise = 1'b1; tick(); tck_rise = 1'b0;
    chk("R3", "no strobe after TDI slot", bit_vld, 1'b0);
    tmsc_in = tms; tck_rise = 1'b1; tick(); tck_rise = 1'b0;
    chk("R3", "no strobe after TMS slot", bit_vld, 1'b0);
    tmsc_in = tdo; tck_rise = 1'b1; tick(); tck_rise = 1'b0;
    chk("R3", "strobe after TDO slot", bit_vld, 1'b1);
    chk("R4", "inverted TDI slot", bit_tdi, tdi);
    chk("R5", "TMS slot", bit_tms, tms);
    chk("R5", "TDO slot", bit_tdo, tdo);
    tmsc_in = 1'($urandom);
    tick();
    chk("R8", "single-cycle strobe", bit_vld, 1'b0);
    chk("R8", "hold TDI", bit_tdi, tdi);
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) tick();
    chk("R1", "vld in reset", bit_vld, 1'b0);
    rst = 1'b0;
    tick();
    chk("R1", "vld after reset", bit_vld, 1'b0);
    chk("R1", "tdi after reset", bit_tdi, 1'b0);

    // R2 / R9: four-wire pass-through, line noise ignored
    cur_req = "R2";
    for (int i = 0; i < 80; i++) begin
      tck_rise = 1'($urandom); tmsc_in = 1'($urandom);
      tdi_in = 1'($urandom); tms_in = 1'($urandom); tdo_in = 1'($urandom);
      tick();
    end
    tck_rise = 1'b1; tdi_in = 1; tms_in = 0; tdo_in = 1; tmsc_in = 0; tick();
    tck_rise = 1'b0;
    chk("R2", "four-wire tdi", bit_tdi, 1'b1);
    chk("R9", "line ignored in four-wire", bit_tms, 1'b0);

    // R6: entry; first edge is TMS, TDI carried over (last TDI slot: none -> 0)
    cur_req = "R6";
    oscan_mode = 1'b1; tmsc_in = 1'b1; tck_rise = 1'b1; tick(); tck_rise = 1'b0;
    chk("R6", "no strobe on entry edge", bit_vld, 1'b0);
    tmsc_in = 1'b0; tck_rise = 1'b1; tick(); tck_rise = 1'b0;
    chk("R6", "strobe on second edge", bit_vld, 1'b1);
    chk("R6", "carried TDI", bit_tdi, 1'b0);
    chk("R6", "entry TMS", bit_tms, 1'b1);
    tick();

    // R3/R4/R5/R9: all combinations, pin inputs randomized
    cur_req = "R4";
    for (int c = 0; c < 8; c++) send_bit(c[2], c[1], c[0]);

    // R7: leave mid-bit, then re-enter; carried TDI is the last TDI slot (1)
    cur_req = "R7";
    send_bit(1'b1, 1'b0, 1'b0);
    edge_line(1'b0);               // TDI slot -> TDI=1
    edge_line(1'b1);               // TMS slot
    oscan_mode = 1'b0; tick();
    chk("R7", "partial bit dropped", bit_vld, 1'b0);
    tick();
    oscan_mode = 1'b1;
    edge_line(1'b0);
    chk("R7", "no strobe on re-entry edge", bit_vld, 1'b0);
    tmsc_in = 1'b1; tck_rise = 1'b1; tick(); tck_rise = 1'b0;
    chk("R7", "re-entry strobe", bit_vld, 1'b1);
    chk("R7", "re-entry carried TDI", bit_tdi, 1'b1);
    tick();

    // R8: idle with line noise, no strobe
    cur_req = "R8";
    for (int i = 0; i < 20; i++) begin tmsc_in = 1'($urandom); tick(); end

    // R3: back-to-back edges
    cur_req = "R3";
    tck_rise = 1'b1;
    for (int i = 0; i < 30; i++) begin tmsc_in = 1'($urandom); tick(); end
    tck_rise = 1'b0;

    // Long random run with occasional mode changes
    cur_req = "R9";
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 40) == 0) oscan_mode = ~oscan_mode;
      tck_rise = 1'($urandom); tmsc_in = 1'($urandom);
      tdi_in = 1'($urandom); tms_in = 1'($urandom); tdo_in = 1'($urandom);
      tick();
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule